// File: doc/BRIEF.md
# Protected Zone and Check Address Mapper

This block sits on the address path between a bus master and main memory, where memory words are guarded by checksums. The checksums live in ordinary memory next to the data. For each data-word address it decides whether the address lies in one of the configured protected zones. When it does, the block computes two values. The first is the word address of the check word that holds that data word's checksum. The second is the slot of the checksum inside that check word. A downstream sequencer uses these values to fetch or update the check word. Encoding and checking of the checksums are not part of this block.

Requests arrive on a valid/ready stream. Each request carries a word address, a write flag and write data. Results leave on a second valid/ready stream one cycle after acceptance.

- A request is accepted on a clock edge where both `in_valid` and `in_ready` are high.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output field is held unchanged.

Each zone entry holds:

- a check-region base (`base`);
- a shift-in mask;
- a compare pattern;
- a don't-care flag word;
- a control word with an enable bit and a code select.

The master programs these registers with ordinary requests to a reserved window of word addresses. Such requests are flagged as register accesses on the output and must not be forwarded to memory.

Top module: `zone_chk_mapper`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every zone entry is disabled, so no address is reported as protected.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all output fields stay stable. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R3: An enabled zone matches an address when every bit position either has its don't-care flag set to 1 or has the address bit equal to the pattern bit. An unmatched data address gives `out_prot`=0 with `out_chk_addr` and `out_slot` both 0.
- R4: When both zone entries match, entry 0 is reported (`out_zone`=0) and its settings are used.
- R5: With code select 0 (parity, C = WORD_W), `out_chk_addr` = base OR ((effective mask AND address) >> log2(WORD_W)). This is a shift by 5 for 32-bit words.
- R6: With code select 1 (SEC-DED, C = WORD_W/8), the same formula uses a shift of log2(WORD_W/8). This is a shift by 2 for 32-bit words.
- R7: `out_slot` equals the address modulo C, where C is the code's value from R5 or R6.
- R8: The lowest log2(WORD_W/8) mask bits are not stored and always read back as 1. For either code, the effective mask is the stored mask with its lowest log2(C) bits forced to 1.
- R9: Addresses whose upper bits equal those of `REG_BASE` (a window of NZONE*8 words) are register accesses. Word offset z*8+r selects register r of zone z: 0 base, 1 mask, 2 pattern, 3 don't-care flags, 4 control (bit 0 enable, bit 1 code select). The result has `out_reg`=1 and `out_prot`=0. A write updates the register before the next accepted request. A read returns the register's contents on `out_rdata`.
- R10: Register offsets 5 to 7 of each zone read as 0, and writes to them change no register.
- R11: Each accepted request produces exactly one result, valid in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | ADDR_W | Data-word address |
| in_we | input | 1 | Request is a write |
| in_wdata | input | ADDR_W | Write data (used for register writes) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | ADDR_W | Address of the request |
| out_reg | output | 1 | Request hit the register window |
| out_rdata | output | ADDR_W | Register read data, 0 otherwise |
| out_prot | output | 1 | Address lies in an enabled zone |
| out_zone | output | ZW | Index of the matched zone |
| out_chk_addr | output | ADDR_W | Check-word address |
| out_slot | output | log2(WORD_W) | Checksum slot inside the check word |

## Verification
The bench builds the block with its defaults:

- 32-bit addresses and 32-bit words, which gives shifts of 5 for parity and 2 for SEC-DED;
- two zone entries;
- a register window at word address 0xFFFFFF00.

With two entries, the bench can program overlapping zones and observe the priority of entry 0. It can also observe the exact boundary where a wider zone takes over from a narrower one. Both codes are reachable through the control word, so shift width, slot range and the forced low mask bits can be checked against hand-computed values. Holding `out_ready` low exposes the stall and release ordering of the single output stage.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

  // Register slots inside one zone entry (word offset within the zone)
  typedef enum logic [2:0] {
    RS_BASE  = 3'd0,
    RS_MASK  = 3'd1,
    RS_PAT   = 3'd2,
    RS_DCARE = 3'd3,
    RS_CTRL  = 3'd4
  } reg_slot_e;

  // Code selector held in control bit 1
  typedef enum logic {
    CODE_PARITY = 1'b0,
    CODE_SECDED = 1'b1
  } code_e;

  localparam int SLOT_LOG2 = 3;

endpackage

// File: rtl/zcm_cfg_regs.sv
module zcm_cfg_regs
  import zcm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NZONE     = 2,
  parameter int LOG2C_MIN = 2,
  parameter int WIN_LOG2  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WIN_LOG2-1:0]           idx,
  input  logic [ADDR_W-1:0]             wdata,
  output logic [ADDR_W-1:0]             rdata,
  output logic [NZONE-1:0][ADDR_W-1:0]  base_o,
  output logic [NZONE-1:0][ADDR_W-1:0]  mask_o,
  output logic [NZONE-1:0][ADDR_W-1:0]  pat_o,
  output logic [NZONE-1:0][ADDR_W-1:0]  dcare_o,
  output logic [NZONE-1:0]              en_o,
  output logic [NZONE-1:0]              code_o
);

  localparam int ZSEL_W = WIN_LOG2 - SLOT_LOG2;
  localparam logic [LOG2C_MIN-1:0] LOW_ONES = '1;

  logic [ZSEL_W-1:0]    zsel;
  reg_slot_e            rsel;
  logic [SLOT_LOG2-1:0] rsel_raw;

  assign zsel     = idx[WIN_LOG2-1:SLOT_LOG2];
  assign rsel_raw = idx[SLOT_LOG2-1:0];
  assign rsel     = reg_slot_e'(rsel_raw);

  logic [NZONE-1:0][ADDR_W-1:0] rd_zone;

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    logic                          hit;
    logic [ADDR_W-1:0]             base_q, pat_q, dcare_q;
    logic [ADDR_W-1:LOG2C_MIN]     mask_q;
    logic                          en_q, code_q;

    assign hit = wr_en && (zsel == ZSEL_W'(z));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        mask_q  <= '0;
        pat_q   <= '0;
        dcare_q <= '0;
        en_q    <= 1'b0;
        code_q  <= 1'b0;
      end else if (hit) begin
        case (rsel)
          RS_BASE:  base_q  <= wdata;
          RS_MASK:  mask_q  <= wdata[ADDR_W-1:LOG2C_MIN];
          RS_PAT:   pat_q   <= wdata;
          RS_DCARE: dcare_q <= wdata;
          RS_CTRL: begin
            en_q   <= wdata[0];
            code_q <= wdata[1];
          end
          default: ;
        endcase
      end
    end

    assign base_o[z]  = base_q;
    assign mask_o[z]  = {mask_q, LOW_ONES};
    assign pat_o[z]   = pat_q;
    assign dcare_o[z] = dcare_q;
    assign en_o[z]    = en_q;
    assign code_o[z]  = code_q;

    always_comb begin
      case (rsel)
        RS_BASE:  rd_zone[z] = base_q;
        RS_MASK:  rd_zone[z] = {mask_q, LOW_ONES};
        RS_PAT:   rd_zone[z] = pat_q;
        RS_DCARE: rd_zone[z] = dcare_q;
        RS_CTRL:  rd_zone[z] = {{(ADDR_W-2){1'b0}}, code_q, en_q};
        default:  rd_zone[z] = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    for (int z = 0; z < NZONE; z++) begin
      if (zsel == ZSEL_W'(z)) rdata = rd_zone[z];
    end
  end

endmodule

// File: rtl/zcm_zone_match.sv
module zcm_zone_match #(
  parameter int ADDR_W = 32,
  parameter int NZONE  = 2,
  parameter int ZW     = 1
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NZONE-1:0][ADDR_W-1:0]  pat,
  input  logic [NZONE-1:0][ADDR_W-1:0]  dcare,
  input  logic [NZONE-1:0]              en,
  output logic                          any_hit,
  output logic [ZW-1:0]                 hit_idx
);

  logic [NZONE-1:0] hit;

  for (genvar z = 0; z < NZONE; z++) begin : g_cmp
    logic [ADDR_W-1:0] bit_ok;
    assign bit_ok = ~(addr ^ pat[z]) | dcare[z];
    assign hit[z] = en[z] && (&bit_ok);
  end

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int z = NZONE - 1; z >= 0; z--) begin
      if (hit[z]) hit_idx = ZW'(z);
    end
  end

  assign any_hit = |hit;

endmodule

// File: rtl/zcm_addr_calc.sv
module zcm_addr_calc #(
  parameter int ADDR_W    = 32,
  parameter int LOG2C_PAR = 5,
  parameter int LOG2C_SEC = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    base,
  input  logic [ADDR_W-1:0]    mask,
  input  logic                 code,
  output logic [ADDR_W-1:0]    chk_addr,
  output logic [LOG2C_PAR-1:0] slot
);

  localparam int NCODE = 2;
  localparam int SH [NCODE] = '{LOG2C_PAR, LOG2C_SEC};

  logic [NCODE-1:0][ADDR_W-1:0]    chk_v;
  logic [NCODE-1:0][LOG2C_PAR-1:0] slot_v;

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    localparam logic [ADDR_W-1:0] LOW = ADDR_W'((64'd1 << SH[c]) - 64'd1);
    logic [ADDR_W-1:0] m_eff;
    assign m_eff     = mask | LOW;
    assign chk_v[c]  = base | ((m_eff & addr) >> SH[c]);
    assign slot_v[c] = LOG2C_PAR'(addr & LOW);
  end

  assign chk_addr = chk_v[code];
  assign slot     = slot_v[code];

endmodule

// File: rtl/zone_chk_mapper.sv
module zone_chk_mapper
  import zcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NZONE  = 2,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hFFFF_FF00,
  localparam int ZW        = (NZONE > 1) ? $clog2(NZONE) : 1,
  localparam int LOG2C_PAR = $clog2(WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 in_we,
  input  logic [ADDR_W-1:0]    in_wdata,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_reg,
  output logic [ADDR_W-1:0]    out_rdata,
  output logic                 out_prot,
  output logic [ZW-1:0]        out_zone,
  output logic [ADDR_W-1:0]    out_chk_addr,
  output logic [LOG2C_PAR-1:0] out_slot
);

  localparam int LOG2C_SEC = $clog2(WORD_W / 8);
  localparam int WIN_LOG2  = $clog2(NZONE) + SLOT_LOG2;

  logic                          accept, is_reg, cfg_wr;
  logic [ADDR_W-1:0]             rd_data;
  logic [NZONE-1:0][ADDR_W-1:0]  base_a, mask_a, pat_a, dcare_a;
  logic [NZONE-1:0]              en_a, code_a;
  logic                          any_hit;
  logic [ZW-1:0]                 hit_idx;
  logic [ADDR_W-1:0]             chk_c;
  logic [LOG2C_PAR-1:0]          slot_c;
  logic                          prot_c;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign is_reg   = (in_addr[ADDR_W-1:WIN_LOG2] == REG_BASE[ADDR_W-1:WIN_LOG2]);
  assign cfg_wr   = accept && is_reg && in_we;

  zcm_cfg_regs #(
    .ADDR_W(ADDR_W), .NZONE(NZONE), .LOG2C_MIN(LOG2C_SEC), .WIN_LOG2(WIN_LOG2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
    .idx(in_addr[WIN_LOG2-1:0]), .wdata(in_wdata), .rdata(rd_data),
    .base_o(base_a), .mask_o(mask_a), .pat_o(pat_a), .dcare_o(dcare_a),
    .en_o(en_a), .code_o(code_a)
  );

  zcm_zone_match #(.ADDR_W(ADDR_W), .NZONE(NZONE), .ZW(ZW)) u_match (
    .addr(in_addr), .pat(pat_a), .dcare(dcare_a), .en(en_a),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  zcm_addr_calc #(
    .ADDR_W(ADDR_W), .LOG2C_PAR(LOG2C_PAR), .LOG2C_SEC(LOG2C_SEC)
  ) u_calc (
    .addr(in_addr), .base(base_a[hit_idx]), .mask(mask_a[hit_idx]),
    .code(code_a[hit_idx]), .chk_addr(chk_c), .slot(slot_c)
  );

  assign prot_c = any_hit && !is_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_reg      <= 1'b0;
      out_rdata    <= '0;
      out_prot     <= 1'b0;
      out_zone     <= '0;
      out_chk_addr <= '0;
      out_slot     <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_addr     <= in_addr;
      out_reg      <= is_reg;
      out_rdata    <= (is_reg && !in_we) ? rd_data : '0;
      out_prot     <= prot_c;
      out_zone     <= prot_c ? hit_idx : '0;
      out_chk_addr <= prot_c ? chk_c : '0;
      out_slot     <= prot_c ? slot_c : '0;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/zone_chk_mapper_chk.sv
module zone_chk_mapper_chk #(
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_prot,
  input logic              out_reg,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] out_chk_addr,
  input logic [SLOT_W-1:0] out_slot
);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_chk_addr) && $stable(out_prot)));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  reg_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reg) |-> !out_prot);

  // R3
  unprot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_prot) |-> (out_chk_addr == '0 && out_slot == '0));

endmodule

bind zone_chk_mapper zone_chk_mapper_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(LOG2C_PAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prot(out_prot),
  .out_reg(out_reg), .out_addr(out_addr), .out_chk_addr(out_chk_addr),
  .out_slot(out_slot)
);

// File: tb/sim_zone_chk_mapper.sv
module sim_zone_chk_mapper;

  localparam logic [31:0] RB = 32'hFFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_we = 1'b0, out_ready = 1'b1;
  logic [31:0] in_addr = '0, in_wdata = '0;
  logic        in_ready, out_valid, out_reg, out_prot;
  logic [0:0]  out_zone;
  logic [31:0] out_addr, out_rdata, out_chk_addr;
  logic [4:0]  out_slot;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zone_chk_mapper u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_we(in_we), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_reg(out_reg), .out_rdata(out_rdata), .out_prot(out_prot),
    .out_zone(out_zone), .out_chk_addr(out_chk_addr), .out_slot(out_slot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected check address from the requirement formula
  function automatic logic [31:0] exp_chk(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] m, input bit sec);
    logic [31:0] meff;
    meff = m | (sec ? 32'h3 : 32'h1F);
    return b | ((meff & a) >> (sec ? 2 : 5));
  endfunction

  task automatic xfer(input logic [31:0] a, input logic we, input logic [31:0] wd);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_we = we; in_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr_reg(input int z, input int r, input logic [31:0] v);
    xfer(RB + 32'(z * 8 + r), 1'b1, v);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    xfer(32'h1000_0000, 1'b0, '0);
    chk("R1 prot after reset", {31'b0, out_prot}, 32'd0);
    xfer(RB + 32'd4, 1'b0, '0);
    chk("R1 ctrl zone0 reset", out_rdata, 32'd0);
  endtask

  task automatic t_regs;
    wr_reg(0, 0, 32'h0800_0000); wr_reg(0, 1, 32'h00FF_FF00);
    wr_reg(0, 2, 32'h1000_0000); wr_reg(0, 3, 32'h00FF_FFFF);
    wr_reg(0, 4, 32'h1);
    wr_reg(1, 0, 32'h0C00_0000); wr_reg(1, 1, 32'h0000_FFFC);
    wr_reg(1, 2, 32'h1000_0000); wr_reg(1, 3, 32'h0FFF_FFFF);
    wr_reg(1, 4, 32'h3);
    xfer(RB + 32'd1, 1'b0, '0);
    chk("R8 mask low bits read 1", out_rdata, 32'h00FF_FF03);
    xfer(RB + 32'd10, 1'b0, '0);
    chk("R9 pattern readback", out_rdata, 32'h1000_0000);
    chk("R9 reg flag", {31'b0, out_reg}, 32'd1);
    chk("R9 reg not prot", {31'b0, out_prot}, 32'd0);
    wr_reg(0, 5, 32'hDEAD_BEEF);
    xfer(RB + 32'd5, 1'b0, '0);
    chk("R10 unused slot reads 0", out_rdata, 32'd0);
    xfer(RB + 32'd4, 1'b0, '0);
    chk("R10 ctrl untouched", out_rdata, 32'h1);
    xfer(RB + 32'd0, 1'b0, '0);
    chk("R10 base untouched", out_rdata, 32'h0800_0000);
  endtask

  task automatic t_parity;
    xfer(32'h1012_3457, 1'b0, '0);
    chk("R4 zone0 priority", {31'b0, out_zone}, 32'd0);
    chk("R5 parity chk addr", out_chk_addr, exp_chk(32'h1012_3457, 32'h0800_0000, 32'h00FF_FF00, 0));
    chk("R7 parity slot", {27'b0, out_slot}, 32'h17);
    chk("R3 prot", {31'b0, out_prot}, 32'd1);
    xfer(32'h10FF_FFFF, 1'b1, 32'h5);
    chk("R3 edge inside zone0", {31'b0, out_zone}, 32'd0);
    chk("R7 slot max", {27'b0, out_slot}, 32'h1F);
  endtask

  task automatic t_secded;
    xfer(32'h1234_5677, 1'b0, '0);
    chk("R6 zone1 chosen", {31'b0, out_zone}, 32'd1);
    chk("R6 secded chk addr", out_chk_addr, 32'h0C00_159D);
    chk("R7 secded slot", {27'b0, out_slot}, 32'd3);
    xfer(32'h1100_0000, 1'b0, '0);
    chk("R3 edge past zone0", {31'b0, out_zone}, 32'd1);
    chk("R6 chk at edge", out_chk_addr, exp_chk(32'h1100_0000, 32'h0C00_0000, 32'h0000_FFFC, 1));
  endtask

  task automatic t_nomatch;
    xfer(32'h2000_0000, 1'b0, '0);
    chk("R3 no match prot", {31'b0, out_prot}, 32'd0);
    chk("R3 no match chk", out_chk_addr, 32'd0);
    wr_reg(1, 4, 32'h0);
    xfer(32'h1234_5677, 1'b0, '0);
    chk("R3 disabled zone", {31'b0, out_prot}, 32'd0);
  endtask

  task automatic t_stall;
    @(negedge clk); out_ready = 1'b0;
    xfer(32'h1012_3457, 1'b0, '0);
    chk("R11 result next cycle", {31'b0, out_valid}, 32'd1);
    chk("R2 in_ready low", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b1; in_addr = 32'h1000_0040; in_we = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 held addr", out_addr, 32'h1012_3457);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second taken", out_addr, 32'h1000_0040);
    chk("R5 second chk", out_chk_addr, exp_chk(32'h1000_0040, 32'h0800_0000, 32'h00FF_FF00, 0));
    @(posedge clk); @(negedge clk);
    chk("R11 single result", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_parity;
    t_secded;
    t_nomatch;
    t_stall;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule